// File: doc/BRIEF.md
# Network Controller Command and Status Registers

This block is the register file that a host processor uses to command and observe a network controller. The host reaches it through one narrow port with two locations: a pointer location that holds a 2-bit register index, and a data location that reads or writes the register the pointer names. Register 0 is the command and status word. Its bits are a mix of four kinds: status flags that hardware events raise and that the host clears by writing one, command bits that can only be set, an interrupt enable that simply stores the written value, and two summary bits computed from the flags. Registers 1 to 3 are plain storage. Registers 1 and 2 also carry the address of the configuration record in SRAM.

When the host sets the initialise command, the block reads twelve consecutive 16-bit words from SRAM. From them it takes the operating mode, the 48-bit station address, the 64-bit receive filter, and the base address and size of the transmit and receive descriptor rings. It then hands these values to the DMA engines. It turns the engines on unless the mode word disables them, pulses a ring-index reset, and raises the init-complete flag. The engines stay disabled while the fetch is running. The block drives the interrupt line from the summary flag and the enable bit.

Top module: `nic_csr_block`

## Requirements
- R1: Writing the pointer location (`acc_adr`=1) stores `acc_wdata[1:0]`. Reading it returns that index in bits 1:0 with zeros above. Registers 1 to 3 read back exactly what was last written to them through the data location (`acc_adr`=0).
- R2: After reset, register 0 reads 0x0004 (only the stop bit, bit 2, is set), and `irq`, `tx_enable`, `rx_enable`, `tx_demand` and `init_busy` are low.
- R3: The register 0 flags babble (bit 14), collision error (13), missed frame (12), memory error (11), receive done (10), transmit done (9) and init-complete (8) are cleared by writing 1 and are unchanged by writing 0. Each of the first six is set by a one-cycle pulse on `evt_in[5:0]` (in the same order, bit 5 babble down to bit 0 transmit done). When an event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R4: Transmit demand (bit 3), start (bit 1) and initialise (bit 0) are set by writing 1 and are unchanged by writing 0. Setting start or initialise clears stop. Transmit demand drives `tx_demand` and is cleared only by `tx_demand_ack`.
- R5: A write with the stop bit set sets stop and leaves start and initialise clear, even if the same write also sets them. No fetch starts.
- R6: The interrupt enable (bit 6) takes the value of bit 6 of every register 0 write.
- R7: Bit 15 reads as the OR of babble, collision error, missed frame and memory error. Bit 7 reads as the OR of babble, missed frame, memory error, receive done, transmit done and init-complete.
- R8: While the memory error flag is set, transmit-on (bit 4) and receive-on (bit 5) are clear, and `tx_enable` and `rx_enable` are low.
- R9: While stop is set, init-complete reads 0.
- R10: `irq` is high exactly when bit 7 and the interrupt enable are both set.
- R11: Initialise fetches 12 words starting at byte address {register 2 bits 7:0, register 1}, in steps of 2. Word 0 is the mode. Words 1 to 3 form the station address and words 4 to 7 the filter, low word first. Word 8 and bits 7:0 of word 9 form the receive ring base, and bits 15:13 of word 9 give the receive ring length as 2 to that power. Words 10 and 11 give the same fields for the transmit ring.
- R12: When the fetch completes, `ring_idx_rst` pulses for one cycle, init-complete is set and initialise is cleared. Transmit-on becomes the inverse of mode bit 1 and receive-on the inverse of mode bit 0. During the fetch `init_busy` is high and both enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Host access strobe |
| acc_we | input | 1 | Host access is a write |
| acc_adr | input | 1 | 1 selects the pointer location, 0 the data location |
| acc_wdata | input | 16 | Host write data |
| acc_rdata | output | 16 | Host read data for the location on `acc_adr` |
| evt_in | input | 6 | Event pulses: babble, collision, missed, memory error, rx done, tx done |
| tx_demand_ack | input | 1 | Transmit engine has taken the demand |
| mem_rd_en | output | 1 | SRAM read request; data returns one cycle later |
| mem_addr | output | 24 | SRAM byte address of the requested word |
| mem_rdata | input | 16 | SRAM read data |
| irq | output | 1 | Interrupt request |
| tx_enable | output | 1 | Transmit engine enable |
| rx_enable | output | 1 | Receive engine enable |
| tx_demand | output | 1 | Transmit poll request |
| init_busy | output | 1 | Configuration fetch in progress |
| ring_idx_rst | output | 1 | One-cycle pulse that rewinds both ring indices |
| cfg_mode | output | 16 | Fetched mode word |
| station_addr | output | 48 | Fetched station address |
| addr_filter | output | 64 | Fetched receive filter |
| rx_ring_base | output | 24 | Receive ring base address |
| rx_ring_len | output | 8 | Receive ring entry count |
| tx_ring_base | output | 24 | Transmit ring base address |
| tx_ring_len | output | 8 | Transmit ring entry count |

## Verification
Two functions can hit the same flag in the same cycle: a hardware event that raises a flag, and a host write that clears it. The bench provokes this by driving an event pulse on the same clock edge as a write-one-to-clear of that flag, and it expects the flag to survive. Stop and start/initialise can likewise arrive in one write; the bench sends all three together and expects stop alone, with no fetch starting. A sweep over all 64 event patterns compares the full register 0 word against a value computed from the pattern.

// File: rtl/nic_csr_pkg.sv
package nic_csr_pkg;

    localparam int REG_W      = 16;
    localparam int ADDR_W     = 24;
    localparam int N_REGS     = 4;
    localparam int SEL_W      = $clog2(N_REGS);
    localparam int INIT_WORDS = 12;
    localparam int CNT_W      = $clog2(INIT_WORDS + 1);
    localparam int LEN_LOG_W  = 3;
    localparam int RING_LEN_W = 1 << LEN_LOG_W;
    localparam int N_EVT      = 6;

    // Register 0 bit positions
    localparam int B_INIT = 0;
    localparam int B_STRT = 1;
    localparam int B_STOP = 2;
    localparam int B_TDMD = 3;
    localparam int B_TXON = 4;
    localparam int B_RXON = 5;
    localparam int B_INEA = 6;
    localparam int B_INTR = 7;
    localparam int B_IDON = 8;
    localparam int B_TINT = 9;
    localparam int B_RINT = 10;
    localparam int B_MERR = 11;
    localparam int B_MISS = 12;
    localparam int B_CERR = 13;
    localparam int B_BABL = 14;
    localparam int B_ERR  = 15;

    typedef struct packed {
        logic babl;
        logic cerr;
        logic miss;
        logic merr;
        logic rint;
        logic tint;
    } evt_t;

    typedef struct packed {
        logic babl;
        logic cerr;
        logic miss;
        logic merr;
        logic rint;
        logic tint;
        logic idon;
        logic inea;
        logic rxon;
        logic txon;
        logic tdmd;
        logic stop;
        logic strt;
        logic init;
    } csr0_t;

    typedef struct packed {
        logic [REG_W-1:0]     mode;
        logic [47:0]          padr;
        logic [63:0]          ladrf;
        logic [ADDR_W-1:0]    rx_base;
        logic [LEN_LOG_W-1:0] rx_log;
        logic [ADDR_W-1:0]    tx_base;
        logic [LEN_LOG_W-1:0] tx_log;
    } init_cfg_t;

    typedef enum logic {F_IDLE, F_RUN} fetch_st_t;

    function automatic logic err_sum(csr0_t s);
        return s.babl | s.cerr | s.miss | s.merr;
    endfunction

    function automatic logic intr_sum(csr0_t s);
        return s.babl | s.miss | s.merr | s.rint | s.tint | s.idon;
    endfunction

    function automatic logic [REG_W-1:0] csr0_view(csr0_t s);
        logic [REG_W-1:0] r;
        r         = '0;
        r[B_INIT] = s.init;
        r[B_STRT] = s.strt;
        r[B_STOP] = s.stop;
        r[B_TDMD] = s.tdmd;
        r[B_TXON] = s.txon;
        r[B_RXON] = s.rxon;
        r[B_INEA] = s.inea;
        r[B_INTR] = intr_sum(s);
        r[B_IDON] = s.idon;
        r[B_TINT] = s.tint;
        r[B_RINT] = s.rint;
        r[B_MERR] = s.merr;
        r[B_MISS] = s.miss;
        r[B_CERR] = s.cerr;
        r[B_BABL] = s.babl;
        r[B_ERR]  = err_sum(s);
        return r;
    endfunction

endpackage

// File: rtl/nic_csr_status.sv
module nic_csr_status
    import nic_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  evt_t             evt,
    input  logic             demand_ack,
    input  logic             fetch_done,
    input  logic [REG_W-1:0] fetch_mode,
    output csr0_t            q
);

    csr0_t n;

    always_comb begin
        n = q;
        if (demand_ack) n.tdmd = 1'b0;
        if (wr_en) begin
            if (wdata[B_BABL]) n.babl = 1'b0;
            if (wdata[B_CERR]) n.cerr = 1'b0;
            if (wdata[B_MISS]) n.miss = 1'b0;
            if (wdata[B_MERR]) n.merr = 1'b0;
            if (wdata[B_RINT]) n.rint = 1'b0;
            if (wdata[B_TINT]) n.tint = 1'b0;
            if (wdata[B_IDON]) n.idon = 1'b0;
            if (wdata[B_TDMD]) n.tdmd = 1'b1;
            if (wdata[B_STRT]) begin
                n.strt = 1'b1;
                n.stop = 1'b0;
            end
            if (wdata[B_INIT]) begin
                n.init = 1'b1;
                n.stop = 1'b0;
            end
            if (wdata[B_STOP]) begin
                n.stop = 1'b1;
                n.strt = 1'b0;
                n.init = 1'b0;
            end
            n.inea = wdata[B_INEA];
        end
        // hardware events win over a same-cycle clear
        n.babl = n.babl | evt.babl;
        n.cerr = n.cerr | evt.cerr;
        n.miss = n.miss | evt.miss;
        n.merr = n.merr | evt.merr;
        n.rint = n.rint | evt.rint;
        n.tint = n.tint | evt.tint;
        if (fetch_done) begin
            n.txon = ~fetch_mode[1];
            n.rxon = ~fetch_mode[0];
            n.idon = 1'b1;
            n.init = 1'b0;
        end
        if (n.merr) begin
            n.txon = 1'b0;
            n.rxon = 1'b0;
        end
        if (n.stop) n.idon = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q      <= '0;
            q.stop <= 1'b1;
        end else begin
            q <= n;
        end
    end

    // R5
    stop_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wdata[B_STOP]) |=> (q.stop && !q.strt && !q.init));

    // R3
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wdata[B_TINT] && !evt.tint) |=> !q.tint);

    // R8
    merr_kill_chk: assert property (@(posedge clk) disable iff (rst)
        q.merr |-> (!q.txon && !q.rxon));

    // R9
    stop_idon_chk: assert property (@(posedge clk) disable iff (rst)
        q.stop |-> !q.idon);

endmodule

// File: rtl/nic_csr_fetch.sv
module nic_csr_fetch
    import nic_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              abort,
    input  logic [ADDR_W-1:0] base,
    input  logic [REG_W-1:0]  mem_rdata,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              busy,
    output logic              done,
    output init_cfg_t         cfg
);

    fetch_st_t        st;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cap_idx;
    logic             cap_vld;

    assign busy      = (st == F_RUN);
    assign mem_rd_en = busy && (cnt < CNT_W'(INIT_WORDS));
    assign mem_addr  = base + (ADDR_W'(cnt) << 1);
    assign done      = cap_vld && (cap_idx == CNT_W'(INIT_WORDS - 1));

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            st      <= F_IDLE;
            cnt     <= '0;
            cap_vld <= 1'b0;
            cap_idx <= '0;
        end else begin
            cap_vld <= mem_rd_en;
            cap_idx <= cnt;
            if (start) begin
                st  <= F_RUN;
                cnt <= '0;
            end else if (done) begin
                st <= F_IDLE;
            end else if (mem_rd_en) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (cap_vld && !abort) begin
            if (cap_idx == 0)
                cfg.mode <= mem_rdata;
            else if (cap_idx <= 3)
                cfg.padr[(int'(cap_idx) - 1) * 16 +: 16] <= mem_rdata;
            else if (cap_idx <= 7)
                cfg.ladrf[(int'(cap_idx) - 4) * 16 +: 16] <= mem_rdata;
            else if (cap_idx == 8)
                cfg.rx_base[15:0] <= mem_rdata;
            else if (cap_idx == 9) begin
                cfg.rx_base[ADDR_W-1:16] <= mem_rdata[ADDR_W-17:0];
                cfg.rx_log <= mem_rdata[REG_W-1 -: LEN_LOG_W];
            end else if (cap_idx == 10)
                cfg.tx_base[15:0] <= mem_rdata;
            else begin
                cfg.tx_base[ADDR_W-1:16] <= mem_rdata[ADDR_W-17:0];
                cfg.tx_log <= mem_rdata[REG_W-1 -: LEN_LOG_W];
            end
        end
    end

    // R11
    fetch_idx_chk: assert property (@(posedge clk) disable iff (rst)
        cap_vld |-> (cap_idx < CNT_W'(INIT_WORDS)));

    // R12
    done_in_run_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

endmodule

// File: rtl/nic_csr_block.sv
module nic_csr_block
    import nic_csr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  acc_en,
    input  logic                  acc_we,
    input  logic                  acc_adr,
    input  logic [15:0]           acc_wdata,
    output logic [15:0]           acc_rdata,
    input  logic [5:0]            evt_in,
    input  logic                  tx_demand_ack,
    output logic                  mem_rd_en,
    output logic [23:0]           mem_addr,
    input  logic [15:0]           mem_rdata,
    output logic                  irq,
    output logic                  tx_enable,
    output logic                  rx_enable,
    output logic                  tx_demand,
    output logic                  init_busy,
    output logic                  ring_idx_rst,
    output logic [15:0]           cfg_mode,
    output logic [47:0]           station_addr,
    output logic [63:0]           addr_filter,
    output logic [23:0]           rx_ring_base,
    output logic [7:0]            rx_ring_len,
    output logic [23:0]           tx_ring_base,
    output logic [7:0]            tx_ring_len
);

    logic [SEL_W-1:0] sel_q;
    logic [REG_W-1:0] plain_q [N_REGS];
    csr0_t            csr_q;
    init_cfg_t        cfg;
    logic             busy;
    logic             done;
    logic             data_wr;

    assign data_wr = acc_en && acc_we && !acc_adr;

    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= '0;
        else if (acc_en && acc_we && acc_adr)
            sel_q <= acc_wdata[SEL_W-1:0];
    end

    for (genvar k = 0; k < N_REGS; k++) begin : g_plain
        if (k == 0) begin : g_none
            assign plain_q[k] = '0;
        end else begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)
                    plain_q[k] <= '0;
                else if (data_wr && sel_q == SEL_W'(k))
                    plain_q[k] <= acc_wdata;
            end
        end
    end

    always_comb begin
        if (acc_adr)
            acc_rdata = {{(REG_W-SEL_W){1'b0}}, sel_q};
        else if (sel_q == '0)
            acc_rdata = csr0_view(csr_q);
        else
            acc_rdata = plain_q[sel_q];
    end

    nic_csr_status u_status (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (data_wr && sel_q == '0),
        .wdata      (acc_wdata),
        .evt        (evt_t'(evt_in)),
        .demand_ack (tx_demand_ack),
        .fetch_done (done),
        .fetch_mode (cfg.mode),
        .q          (csr_q)
    );

    nic_csr_fetch u_fetch (
        .clk       (clk),
        .rst       (rst),
        .start     (csr_q.init && !busy),
        .abort     (csr_q.stop),
        .base      ({plain_q[2][ADDR_W-17:0], plain_q[1]}),
        .mem_rdata (mem_rdata),
        .mem_rd_en (mem_rd_en),
        .mem_addr  (mem_addr),
        .busy      (busy),
        .done      (done),
        .cfg       (cfg)
    );

    assign irq          = intr_sum(csr_q) && csr_q.inea;
    assign tx_enable    = csr_q.txon && !busy;
    assign rx_enable    = csr_q.rxon && !busy;
    assign tx_demand    = csr_q.tdmd;
    assign init_busy    = busy;
    assign ring_idx_rst = done;
    assign cfg_mode     = cfg.mode;
    assign station_addr = cfg.padr;
    assign addr_filter  = cfg.ladrf;
    assign rx_ring_base = cfg.rx_base;
    assign tx_ring_base = cfg.tx_base;
    assign rx_ring_len  = RING_LEN_W'(1) << cfg.rx_log;
    assign tx_ring_len  = RING_LEN_W'(1) << cfg.tx_log;

    // R10
    irq_enable_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> csr_q.inea);

    // R12
    idle_engines_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> (!tx_enable && !rx_enable));

endmodule

// File: tb/nic_csr_block_tb.sv
module nic_csr_block_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        acc_en, acc_we, acc_adr;
    logic [15:0] acc_wdata, acc_rdata;
    logic [5:0]  evt_in;
    logic        tx_demand_ack;
    logic        mem_rd_en;
    logic [23:0] mem_addr;
    logic [15:0] mem_rdata;
    logic        irq, tx_enable, rx_enable, tx_demand, init_busy, ring_idx_rst;
    logic [15:0] cfg_mode;
    logic [47:0] station_addr;
    logic [63:0] addr_filter;
    logic [23:0] rx_ring_base, tx_ring_base;
    logic [7:0]  rx_ring_len, tx_ring_len;

    logic [15:0] sram [256];
    int total = 0;
    int fails = 0;

    always #2 clk = ~clk;

    always @(posedge clk) if (mem_rd_en) mem_rdata <= sram[mem_addr[8:1]];

    nic_csr_block u_dut (
        .clk(clk), .rst(rst), .acc_en(acc_en), .acc_we(acc_we), .acc_adr(acc_adr),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .evt_in(evt_in),
        .tx_demand_ack(tx_demand_ack), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .irq(irq), .tx_enable(tx_enable), .rx_enable(rx_enable),
        .tx_demand(tx_demand), .init_busy(init_busy), .ring_idx_rst(ring_idx_rst),
        .cfg_mode(cfg_mode), .station_addr(station_addr), .addr_filter(addr_filter),
        .rx_ring_base(rx_ring_base), .rx_ring_len(rx_ring_len),
        .tx_ring_base(tx_ring_base), .tx_ring_len(tx_ring_len)
    );

    task automatic report();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [15:0] d);
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b1; acc_adr = a; acc_wdata = d;
        @(negedge clk);
        acc_en = 1'b0; acc_we = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [15:0] d);
        acc_adr = a;
        #1 d = acc_rdata;
    endtask

    task automatic pulse_evt(input logic [5:0] m);
        @(negedge clk);
        evt_in = m;
        @(negedge clk);
        evt_in = '0;
    endtask

    task automatic do_init(input logic [15:0] base_b, input logic [15:0] mode,
                           input logic [2:0] rl, input logic [2:0] tl, input logic [7:0] seed);
        logic [15:0] w [12];
        logic [15:0] r0;
        logic seen = 1'b0;
        logic enbad = 1'b0;
        w[0] = mode;
        for (int k = 1; k < 4; k++) w[k] = {seed, 8'(8'h10 + k)};
        for (int k = 4; k < 8; k++) w[k] = {~seed, 8'(8'h20 + k)};
        w[8]  = 16'h0200 + 16'(seed);
        w[9]  = {rl, 5'b0, 8'h01};
        w[10] = 16'h0400 + 16'(seed);
        w[11] = {tl, 5'b0, 8'h02};
        for (int k = 0; k < 12; k++) sram[8'(base_b >> 1) + 8'(k)] = w[k];
        wr(1, 16'd1); wr(0, base_b);
        wr(1, 16'd2); wr(0, 16'h0000);
        wr(1, 16'd0); wr(0, 16'h0001);
        for (int i = 0; i < 40 && !seen; i++) begin
            @(negedge clk);
            if (init_busy && (tx_enable || rx_enable)) enbad = 1'b1;
            if (ring_idx_rst) seen = 1'b1;
        end
        @(negedge clk);
        chk("R12 ring index reset pulse", 64'(seen), 64'(1));
        chk("R12 enables low while fetching", 64'(enbad), 64'(0));
        chk("R12 busy cleared", 64'(init_busy), 64'(0));
        chk("R11 mode", 64'(cfg_mode), 64'(mode));
        chk("R11 station address", 64'(station_addr), 64'({w[3], w[2], w[1]}));
        chk("R11 filter", addr_filter, {w[7], w[6], w[5], w[4]});
        chk("R11 rx base", 64'(rx_ring_base), 64'({8'h01, w[8]}));
        chk("R11 tx base", 64'(tx_ring_base), 64'({8'h02, w[10]}));
        chk("R11 rx ring length", 64'(rx_ring_len), 64'(1) << rl);
        chk("R11 tx ring length", 64'(tx_ring_len), 64'(1) << tl);
        chk("R12 tx enable from mode", 64'(tx_enable), 64'(!mode[1]));
        chk("R12 rx enable from mode", 64'(rx_enable), 64'(!mode[0]));
        rd(0, r0);
        chk("R12 reg0 after init", 64'(r0 & 16'h0137),
            64'(16'h0100 | (mode[1] ? 16'h0 : 16'h0010) | (mode[0] ? 16'h0 : 16'h0020)));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL R2 watchdog actual=timeout expected=finish");
        report();
    end

    initial begin
        logic [15:0] r;
        logic [15:0] exp0;
        logic exp_on;
        rst = 1'b1; acc_en = 1'b0; acc_we = 1'b0; acc_adr = 1'b0; acc_wdata = '0;
        evt_in = '0; tx_demand_ack = 1'b0;
        for (int i = 0; i < 256; i++) sram[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R2 reset state
        rd(0, r);
        chk("R2 reg0 reset", 64'(r), 64'(16'h0004));
        chk("R2 outputs low", 64'({irq, tx_enable, rx_enable, tx_demand, init_busy}), 64'(0));

        // R1 pointer and plain registers
        for (int k = 1; k < 4; k++) begin
            wr(1, 16'(k));
            wr(0, 16'hA500 + 16'(k * 17));
        end
        for (int k = 3; k >= 0; k--) begin
            wr(1, 16'hFFFC | 16'(k));
            rd(1, r);
            chk("R1 pointer readback", 64'(r), 64'(k));
            if (k != 0) begin
                rd(0, r);
                chk("R1 plain register readback", 64'(r), 64'(16'hA500 + 16'(k * 17)));
            end
        end

        // R11 R12 init sweep over mode disable bits
        for (int m = 0; m < 4; m++)
            do_init(16'(16'h0040 + m * 32), 16'(16'h8000 | m), 3'(m * 3), 3'(7 - m), 8'(8'h31 * m + 5));
        do_init(16'h0100, 16'h0000, 3'd2, 3'd5, 8'h77);

        // R3 R7 R8 R10 event sweep
        exp_on = 1'b1;
        for (int m = 0; m < 64; m++) begin
            logic babl, cerr, miss, merr, rint, tint, e, it;
            {babl, cerr, miss, merr, rint, tint} = 6'(m);
            wr(0, 16'h7F40);
            pulse_evt(6'(m));
            exp_on = exp_on & !merr;
            e  = babl | cerr | miss | merr;
            it = babl | miss | merr | rint | tint;
            exp0 = {e, 6'(m), 1'b0, it, 1'b1, exp_on, exp_on, 4'b0};
            rd(0, r);
            chk("R7 R3 reg0 after events", 64'(r), 64'(exp0));
            chk("R10 irq", 64'(irq), 64'(it));
            chk("R8 engine enables", 64'({tx_enable, rx_enable}), 64'({exp_on, exp_on}));
            wr(0, 16'h0040);
            rd(0, r);
            chk("R3 zero write keeps flags", 64'(r), 64'(exp0));
        end

        // R3 same-cycle event and clear
        wr(0, 16'h7F40);
        pulse_evt(6'b000001);
        @(negedge clk);
        evt_in = 6'b000001; acc_en = 1'b1; acc_we = 1'b1; acc_adr = 1'b0; acc_wdata = 16'h0240;
        @(negedge clk);
        evt_in = '0; acc_en = 1'b0; acc_we = 1'b0;
        rd(0, r);
        chk("R3 event beats clear", 64'(r[9]), 64'(1));
        wr(0, 16'h0240);
        rd(0, r);
        chk("R3 clear by one", 64'(r[9]), 64'(0));

        // R6 R10 enable follows write
        pulse_evt(6'b000010);
        wr(0, 16'h0000);
        rd(0, r);
        chk("R6 enable cleared", 64'(r[6]), 64'(0));
        chk("R10 irq masked", 64'(irq), 64'(0));
        wr(0, 16'h0040);
        chk("R10 irq unmasked", 64'(irq), 64'(1));
        wr(0, 16'h7F40);

        // R9 stop holds init-complete clear
        do_init(16'h0080, 16'h0000, 3'd1, 3'd1, 8'h12);
        wr(0, 16'h0004);
        rd(0, r);
        chk("R9 stop clears init-complete", 64'({r[2], r[8]}), 64'(2'b10));
        wr(0, 16'h0100);
        rd(0, r);
        chk("R9 stays clear while stopped", 64'(r[8]), 64'(0));

        // R5 stop wins
        wr(0, 16'h0007);
        repeat (3) @(negedge clk);
        rd(0, r);
        chk("R5 stop wins", 64'(r[2:0]), 64'(3'b100));
        chk("R5 no fetch", 64'(init_busy), 64'(0));

        // R4 start clears stop, demand set-only
        wr(0, 16'h0002);
        rd(0, r);
        chk("R4 start clears stop", 64'(r[2:0]), 64'(3'b010));
        wr(0, 16'h0008);
        chk("R4 demand set", 64'(tx_demand), 64'(1));
        wr(0, 16'h0000);
        rd(0, r);
        chk("R4 zero write keeps demand and start", 64'({tx_demand, r[1]}), 64'(2'b11));
        @(negedge clk) tx_demand_ack = 1'b1;
        @(negedge clk) tx_demand_ack = 1'b0;
        chk("R4 ack clears demand", 64'(tx_demand), 64'(0));

        report();
    end

endmodule